// File: doc/BRIEF.md
# Real-Time Clock Register Front End with Write Lock

This block is the register front end of a real-time clock. A processor reaches it through a simple memory-mapped port: a write strobe, a read strobe, an address and a data word. Behind it sits a calendar counter block, which is not part of this design. That block reports its day, hour, minute, second and alarm events as single-cycle pulses. The front end keeps the control, interrupt-enable, wake-enable and status registers. It drives the interrupt and wake requests, and it tells the counter block when a one-second update is due.

Every write is refused until software unlocks the register file. It does so by writing a first key word to one unlock register and then a second key word to another. Writing zero to the first unlock register locks the file again. The block counts half periods of the 32 kHz timebase. It raises a busy flag in the status register during the last half period before each one-second update and during the update cycle itself. Software that polls this flag knows when a register access could collide with a counter update.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the status register (offset 0x44) reads 0x80. Control (0x40), interrupt enable (0x48) and wake enable (0x7C) read 0, and irq and wakeReq are low.
- R2: While the file is not unlocked, writes to the control, status, interrupt-enable and wake-enable registers change nothing.
- R3: Writing 0x83E70B13 to offset 0x6C and then 0x95A4F1E0 to offset 0x70 unlocks the file. Register writes take effect from the next cycle.
- R4: Any write to 0x6C other than the first key locks the file, and this includes zero. A write to 0x70 with a wrong value while the first key is pending also locks the file.
- R5: Status bit 7 (power-up) and bit 6 (alarm) clear when a 1 is written to them in an unlocked write. Writing 0 leaves them as they are. Power-up is set only by reset, and alarm is set by evtAlarm; a set in the same cycle wins over a clear.
- R6: Status bits 5, 4, 3 and 2 latch evtDay, evtHour, evtMin and evtSec. Writes do not change them. A status read returns their value and then clears them.
- R7: Control bits 0 (run), 2 (auto-compensation) and 3 (12-hour mode) read back and drive ctrlRun, ctrlAutoComp and ctrlHour12. Bit 7 (split power) drives ctrlSplit and always reads 0. The other bits read 0.
- R8: Status bit 1 reads the control run bit.
- R9: While running, the block counts halfTick pulses modulo HALF_TICKS. Status bit 0 (busy) is high while the count sits at HALF_TICKS-1. secUpdate pulses on the halfTick that ends that state. Clearing run holds the count at zero.
- R10: irq is high when (status bit 6 and interrupt-enable bit 3) or (status bit 2 and interrupt-enable bit 2). Only bits 3 and 2 of interrupt enable are stored.
- R11: wakeReq is high when status bit 6 and wake-enable bit 1 are both set. Only bit 1 of wake enable is stored.
- R12: Reads of unmapped offsets and of the unlock registers return 0. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (needed for read-clear) |
| addr | input | ADDR_W | Byte offset |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr, combinational |
| halfTick | input | 1 | Pulse at each half period of the 32 kHz timebase |
| evtSec | input | 1 | Second event from the counters |
| evtMin | input | 1 | Minute event |
| evtHour | input | 1 | Hour event |
| evtDay | input | 1 | Day event |
| evtAlarm | input | 1 | Alarm match from the counters |
| irq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wake request on alarm |
| secUpdate | output | 1 | One-second update strobe to the counters |
| ctrlRun | output | 1 | Run control |
| ctrlAutoComp | output | 1 | Auto-compensation control |
| ctrlHour12 | output | 1 | 12-hour mode select |
| ctrlSplit | output | 1 | Split power select |

## Verification
The assertions assume a few things about the inputs. Reset is applied before any access. Each strobe and event input holds for whole clock cycles. HALF_TICKS is at least 2, so the busy state cannot reappear straight after an update. The bench drives all inputs on the falling edge, one operation at a time. It keeps halfTick low outside the directed busy sequence, which keeps the count at zero while the random mix runs.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h40;
  localparam logic [7:0] OFF_STAT  = 8'h44;
  localparam logic [7:0] OFF_INTEN = 8'h48;
  localparam logic [7:0] OFF_KEYA  = 8'h6C;
  localparam logic [7:0] OFF_KEYB  = 8'h70;
  localparam logic [7:0] OFF_WAKE  = 8'h7C;

  localparam logic [31:0] KEY_A = 32'h83E7_0B13;
  localparam logic [31:0] KEY_B = 32'h95A4_F1E0;

  // storable bits per register
  localparam logic [7:0] CTRL_MASK  = 8'h8D;
  localparam logic [7:0] CTRL_RMASK = 8'h0D;
  localparam logic [7:0] INTEN_MASK = 8'h0C;
  localparam logic [7:0] WAKE_MASK  = 8'h02;

  localparam int NUM_EVT = 4;

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lockState_t;
  typedef enum logic [2:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_INTEN, SEL_WAKE} rdSel_t;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrStat;
    logic   wrInten;
    logic   wrWake;
    logic   rdStat;
    rdSel_t rdSel;
  } regStrobe_t;
endpackage

// File: rtl/rtc_reg_ctrl.sv
module rtc_reg_ctrl
  import rtc_regfile_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output regStrobe_t        strb,
  output logic              isOpen,
  output logic              isHalf
);
  lockState_t lockQ;
  logic hitCtrl, hitStat, hitInten, hitWake, hitKeyA, hitKeyB;

  assign hitCtrl  = addr == ADDR_W'(OFF_CTRL);
  assign hitStat  = addr == ADDR_W'(OFF_STAT);
  assign hitInten = addr == ADDR_W'(OFF_INTEN);
  assign hitWake  = addr == ADDR_W'(OFF_WAKE);
  assign hitKeyA  = addr == ADDR_W'(OFF_KEYA);
  assign hitKeyB  = addr == ADDR_W'(OFF_KEYB);

  assign isOpen = lockQ == LK_OPEN;
  assign isHalf = lockQ == LK_HALF;

  // unlock sequencer: key A arms, key B opens, anything wrong shuts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= LK_SHUT;
    end else if (wrEn && hitKeyA) begin
      lockQ <= (wrData == DATA_W'(KEY_A)) ? LK_HALF : LK_SHUT;
    end else if (wrEn && hitKeyB && lockQ == LK_HALF) begin
      lockQ <= (wrData == DATA_W'(KEY_B)) ? LK_OPEN : LK_SHUT;
    end
  end

  always_comb begin
    strb.wrCtrl  = wrEn && isOpen && hitCtrl;
    strb.wrStat  = wrEn && isOpen && hitStat;
    strb.wrInten = wrEn && isOpen && hitInten;
    strb.wrWake  = wrEn && isOpen && hitWake;
    strb.rdStat  = rdEn && hitStat;
    if (hitCtrl)       strb.rdSel = SEL_CTRL;
    else if (hitStat)  strb.rdSel = SEL_STAT;
    else if (hitInten) strb.rdSel = SEL_INTEN;
    else if (hitWake)  strb.rdSel = SEL_WAKE;
    else               strb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/rtc_reg_dp.sv
module rtc_reg_dp
  import rtc_regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HALF_TICKS = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [7:0]        wrByte,
  input  logic              halfTick,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic              evtAlarm,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wakeReq,
  output logic              secUpdate,
  output logic              busy,
  output logic [7:0]        ctrlByte,
  output logic [7:0]        statusByte,
  output logic [7:0]        intenByte,
  output logic [7:0]        wakeByte
);
  localparam int CNT_W = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_TICKS - 1);

  logic [7:0] ctrlQ, intenQ, wakeQ;
  logic puQ, alQ;
  logic [NUM_EVT-1:0] evQ;
  logic [CNT_W-1:0] cntQ;
  logic runBit, atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      intenQ <= '0;
      wakeQ  <= '0;
    end else begin
      if (strb.wrCtrl)  ctrlQ  <= wrByte & CTRL_MASK;
      if (strb.wrInten) intenQ <= wrByte & INTEN_MASK;
      if (strb.wrWake)  wakeQ  <= wrByte & WAKE_MASK;
    end
  end

  // sticky flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      puQ <= 1'b1;
      alQ <= 1'b0;
    end else begin
      if (strb.wrStat && wrByte[7]) puQ <= 1'b0;
      if (evtAlarm) alQ <= 1'b1;
      else if (strb.wrStat && wrByte[6]) alQ <= 1'b0;
    end
  end

  // event flags, cleared by a status read
  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            evQ[gi] <= 1'b0;
      else if (evtVec[gi])  evQ[gi] <= 1'b1;
      else if (strb.rdStat) evQ[gi] <= 1'b0;
    end
  end

  assign runBit = ctrlQ[0];
  assign atLast = cntQ == CNT_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cntQ <= '0;
    else if (!runBit)  cntQ <= '0;
    else if (halfTick) cntQ <= atLast ? '0 : cntQ + 1'b1;
  end

  assign busy      = runBit && atLast;
  assign secUpdate = busy && halfTick;

  assign ctrlByte   = ctrlQ & CTRL_RMASK;
  assign statusByte = {puQ, alQ, evQ, runBit, busy};
  assign intenByte  = intenQ;
  assign wakeByte   = wakeQ;

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL:  rdData = DATA_W'(ctrlByte);
      SEL_STAT:  rdData = DATA_W'(statusByte);
      SEL_INTEN: rdData = DATA_W'(intenByte);
      SEL_WAKE:  rdData = DATA_W'(wakeByte);
      default:   rdData = '0;
    endcase
  end

  assign irq     = (alQ && intenQ[3]) || (evQ[0] && intenQ[2]);
  assign wakeReq = alQ && wakeQ[1];

  // split power is a write-only control
  logic unusedSplit;
  assign unusedSplit = ctrlQ[7];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int HALF_TICKS = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              halfTick,
  input  logic              evtSec,
  input  logic              evtMin,
  input  logic              evtHour,
  input  logic              evtDay,
  input  logic              evtAlarm,
  output logic              irq,
  output logic              wakeReq,
  output logic              secUpdate,
  output logic              ctrlRun,
  output logic              ctrlAutoComp,
  output logic              ctrlHour12,
  output logic              ctrlSplit
);
  regStrobe_t strb;
  logic isOpen, isHalf, busy, evtAny, rdStatS, wrStatS;
  logic [7:0] ctrlByte, statusByte, intenByte, wakeByte, ctrlRaw;

  rtc_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .isOpen(isOpen), .isHalf(isHalf)
  );

  rtc_reg_dp #(.DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrData[7:0]),
    .halfTick(halfTick), .evtVec({evtDay, evtHour, evtMin, evtSec}),
    .evtAlarm(evtAlarm), .rdData(rdData), .irq(irq), .wakeReq(wakeReq),
    .secUpdate(secUpdate), .busy(busy), .ctrlByte(ctrlByte),
    .statusByte(statusByte), .intenByte(intenByte), .wakeByte(wakeByte)
  );

  // split bit is held in a separate flop so it never shows on reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlRaw <= '0;
    else if (strb.wrCtrl) ctrlRaw <= wrData[7:0] & CTRL_MASK;
  end

  assign ctrlRun      = ctrlByte[0];
  assign ctrlAutoComp = ctrlByte[2];
  assign ctrlHour12   = ctrlByte[3];
  assign ctrlSplit    = ctrlRaw[7];

  assign evtAny  = evtSec | evtMin | evtHour | evtDay;
  assign rdStatS = strb.rdStat;
  assign wrStatS = strb.wrStat;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic       isOpen,
  input logic       isHalf,
  input logic [7:0] ctrlByte,
  input logic [7:0] statusByte,
  input logic [7:0] intenByte,
  input logic [7:0] wakeByte,
  input logic       rdStatS,
  input logic       wrStatS,
  input logic       evtAny,
  input logic       busy,
  input logic       secUpdate,
  input logic       irq
);
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isOpen |=> ($stable(ctrlByte) && $stable(intenByte) && $stable(wakeByte)));

  p_open_after_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> $past(isHalf));

  p_pu_clear_by_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[7]) |-> $past(wrStatS));

  p_pu_never_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(statusByte[7]));

  p_evt_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatS && !evtAny) |=> (statusByte[5:2] == 4'b0000));

  p_busy_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    secUpdate |=> !busy);

  p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intenByte[3:2] != 2'b00));
endmodule

bind rtc_regfile rtc_regfile_chk i_chk (
  .clk(clk), .rstN(rstN), .isOpen(isOpen), .isHalf(isHalf),
  .ctrlByte(ctrlByte), .statusByte(statusByte), .intenByte(intenByte),
  .wakeByte(wakeByte), .rdStatS(rdStatS), .wrStatS(wrStatS),
  .evtAny(evtAny), .busy(busy), .secUpdate(secUpdate), .irq(irq)
);

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
  localparam int HT = 8;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, halfTick = 0;
  logic [7:0] addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic evtSec = 0, evtMin = 0, evtHour = 0, evtDay = 0, evtAlarm = 0;
  logic irq, wakeReq, secUpdate, ctrlRun, ctrlAutoComp, ctrlHour12, ctrlSplit;

  int nChecks = 0, nErrs = 0;
  bit done = 0;

  // model
  int mLock = 0;
  logic [7:0] mCtrl = 0, mInten = 0, mWake = 0;
  logic mPu = 1, mAl = 0;
  logic [3:0] mEv = 0;

  rtc_regfile #(.HALF_TICKS(HT)) i_rtc_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .halfTick(halfTick),
    .evtSec(evtSec), .evtMin(evtMin), .evtHour(evtHour), .evtDay(evtDay),
    .evtAlarm(evtAlarm), .irq(irq), .wakeReq(wakeReq), .secUpdate(secUpdate),
    .ctrlRun(ctrlRun), .ctrlAutoComp(ctrlAutoComp), .ctrlHour12(ctrlHour12),
    .ctrlSplit(ctrlSplit)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h40:   return mCtrl & 8'h0D;
      8'h44:   return {mPu, mAl, mEv, mCtrl[0], 1'b0};
      8'h48:   return mInten;
      8'h7C:   return mWake;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expIrq();
    return (mAl & mInten[3]) | (mEv[0] & mInten[2]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
    if (a == 8'h6C) mLock = (d == KA) ? 1 : 0;
    else if (a == 8'h70 && mLock == 1) mLock = (d == KB) ? 2 : 0;
    else if (mLock == 2) begin
      case (a)
        8'h40: mCtrl = d[7:0] & 8'h8D;
        8'h44: begin if (d[7]) mPu = 0; if (d[6]) mAl = 0; end
        8'h48: mInten = d[7:0] & 8'h0C;
        8'h7C: mWake = d[7:0] & 8'h02;
        default: ;
      endcase
    end
  endtask

  task automatic rawRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 v = rdData[7:0];
    @(posedge clk);
    @(negedge clk);
    rdEn = 0;
    if (a == 8'h44) mEv = 0;
  endtask

  task automatic doRead(input string tag, input logic [7:0] a);
    logic [7:0] e;
    e = expRead(a);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 check(tag, rdData, {24'h0, e});
    @(posedge clk);
    @(negedge clk);
    rdEn = 0;
    if (a == 8'h44) mEv = 0;
  endtask

  task automatic pulseEvt(input logic [4:0] v);
    @(negedge clk);
    {evtAlarm, evtDay, evtHour, evtMin, evtSec} = v;
    @(posedge clk);
    @(negedge clk);
    {evtAlarm, evtDay, evtHour, evtMin, evtSec} = '0;
    mEv = mEv | v[3:0];
    if (v[4]) mAl = 1;
  endtask

  task automatic pulseHalf();
    @(negedge clk);
    halfTick = 1;
    @(posedge clk);
    @(negedge clk);
    halfTick = 0;
  endtask

  task automatic chkPorts(input string tag);
    check({tag, " irq R10"}, irq, expIrq());
    check({tag, " wake R11"}, wakeReq, mAl & mWake[1]);
    check({tag, " ctrl R7"}, {ctrlSplit, ctrlHour12, ctrlAutoComp, ctrlRun},
          {mCtrl[7], mCtrl[3], mCtrl[2], mCtrl[0]});
  endtask

  task automatic unlock();
    doWrite(8'h6C, KA);
    doWrite(8'h70, KB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrs++; nChecks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] addrs [8] = '{8'h40, 8'h44, 8'h48, 8'h6C, 8'h70, 8'h7C, 8'h00, 8'h4C};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset values
    check("R1 irq", irq, 0);
    check("R1 wake", wakeReq, 0);
    doRead("R1 status", 8'h44);
    doRead("R1 ctrl", 8'h40);
    doRead("R1 inten", 8'h48);
    doRead("R1 wakeen", 8'h7C);

    // R2 locked writes ignored
    doWrite(8'h40, 32'hFF);
    doWrite(8'h48, 32'hFF);
    doWrite(8'h7C, 32'hFF);
    doWrite(8'h44, 32'hFF);
    doRead("R2 ctrl locked", 8'h40);
    doRead("R2 inten locked", 8'h48);
    doRead("R2 wake locked", 8'h7C);
    doRead("R2 status locked", 8'h44);

    // R4 wrong second key, then wrong first key
    doWrite(8'h6C, KA);
    doWrite(8'h70, 32'h1234);
    doWrite(8'h70, KB);
    doWrite(8'h48, 32'h08);
    doRead("R4 wrong key B locks", 8'h48);
    doWrite(8'h6C, 32'h5);
    doWrite(8'h70, KB);
    doWrite(8'h48, 32'h08);
    doRead("R4 wrong key A locks", 8'h48);

    // R3 proper unlock
    unlock();
    doWrite(8'h48, 32'hFF);
    doRead("R3 inten after unlock", 8'h48);
    // R12 unmapped and unlock words read zero
    doWrite(8'h00, 32'hFF);
    doRead("R12 unmapped", 8'h00);
    doRead("R12 keyA reads 0", 8'h6C);
    doRead("R12 keyB reads 0", 8'h70);

    // R7 control bits and split
    doWrite(8'h40, 32'hFF);
    doRead("R7 ctrl readback", 8'h40);
    chkPorts("R7");
    check("R7 split out", ctrlSplit, 1);
    doRead("R8 run in status", 8'h44);

    // R5 alarm, W1C
    pulseEvt(5'b10000);
    doWrite(8'h7C, 32'h02);
    chkPorts("R5 alarm set");
    doWrite(8'h44, 32'h00);
    doRead("R5 write zero keeps", 8'h44);
    doWrite(8'h44, 32'h40);
    doRead("R5 alarm cleared", 8'h44);
    chkPorts("R5 after clear");
    doWrite(8'h44, 32'h80);
    doRead("R5 power-up cleared", 8'h44);

    // R6 events, write-immune, read clear
    pulseEvt(5'b01111);
    doWrite(8'h44, 32'h3C);
    chkPorts("R6 sec irq");
    doRead("R6 events latched", 8'h44);
    doRead("R6 events cleared", 8'h44);

    // R4 relock by zero
    doWrite(8'h6C, 32'h0);
    doWrite(8'h48, 32'h00);
    doRead("R4 zero relocks", 8'h48);

    // R9 busy window
    unlock();
    doWrite(8'h40, 32'h01);
    for (int i = 0; i < HT - 1; i++) pulseHalf();
    rawRead(8'h44, v);
    check("R9 busy in last half", v[0], 1);
    @(negedge clk);
    halfTick = 1;
    #1 check("R9 secUpdate", secUpdate, 1);
    @(posedge clk);
    @(negedge clk);
    halfTick = 0;
    #1 check("R9 secUpdate one cycle", secUpdate, 0);
    rawRead(8'h44, v);
    check("R9 busy after update", v[0], 0);
    for (int i = 0; i < HT - 1; i++) pulseHalf();
    doWrite(8'h40, 32'h00);
    rawRead(8'h44, v);
    check("R9 stop clears busy", v[0], 0);
    doWrite(8'h40, 32'h01);
    pulseHalf();
    rawRead(8'h44, v);
    check("R9 count restarted", v[0], 0);
    doWrite(8'h40, 32'h00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom % 7);
      a = addrs[$urandom % 8];
      case (op)
        0: unlock();
        1: doWrite(8'h6C, ($urandom % 3 == 0) ? 32'h0 : (($urandom % 2 == 0) ? KA : $urandom));
        2: doWrite(8'h70, ($urandom % 2 == 0) ? KB : $urandom);
        3, 4: doWrite(a, $urandom);
        5: pulseEvt(5'($urandom));
        default: doRead("R12 random read", a);
      endcase
      chkPorts("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrs);
    $finish;
  end
endmodule